// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between a 64-bit host register port and a two-wire bus controller core whose internal registers are only eight bits wide. The host does not address those registers directly. It writes a single command word that carries a valid flag, a read/write flag, an opcode, a 3-bit register index and a 32-bit data field. The bridge carries out the internal access over a fixed number of cycles. It then clears the valid flag, and software polls that flag until it reads zero.

On a read, the bridge places the byte it fetched into the data field of the same command word, so one host read returns both the completion flag and the result. Three further host offsets sit next to the command word:

- a read-only core-to-software snapshot word,
- a small interrupt/override register,
- an extended command word.

The bus protocol engine behind the internal port is stood in for by a simple register model.

Top module: `ibr_top`

## Requirements
- R1: After reset the command word (offset 0x1000) reads 0. The core-to-software word (offset 0x1008) reads 0x00F8: bits [7:0] hold the status, bits [15:8] hold clock control and all other bits are 0. Offsets 0x1010 and 0x1018 read 0.
- R2: A command with v=1 (bit 63), r=0 (bit 56), op=6 (bits 60:57) and index (bits 34:32) of 0, 1, 2 or 4 writes data[7:0] into that internal register. These are slave address, data, control and extended slave address.
- R3: After a command with v=1 and op=6 is accepted, v reads 1 for exactly ACC_LAT (default 2) clock cycles and then reads 0.
- R4: A read command (r=1, op=6) completes with data[31:0] = {24'b0, register value}. Every other field keeps the value that was written, and v is 0.
- R5: Index 3 selects clock control on a write, which shows in bits [15:8] of offset 0x1008. On a read it selects the status register, which returns 0xF8.
- R6: A write to the command word while v reads 1 is ignored. The access in progress completes with the original word.
- R7: A command word written with v=0 or with op other than 6 is stored with v=0 and the data field unchanged. No internal register changes.
- R8: A write command to index 7 returns every internal register to its reset value of 0.
- R9: Write commands to indexes 5 and 6 change no register, and read commands to them return 0.
- R10: Offset 0x1010 keeps bits [11:0] of a host write and reads 0 above them. Offset 0x1018 keeps bits [39:0] and reads 0 above them. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 16 | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for host_addr, combinational |

## Verification
The assertions watch four things on every cycle:

- v stays set while the latency counter runs.
- A host write during a busy access leaves the command word untouched.
- A command that is not an internal access never shows v set.
- Index 5/6 writes leave the register file unchanged, and an index-7 write clears it.

Only the bench scenarios can show the end-to-end values. These are the byte that lands in each register, the exact cycle on which v drops, the status and clock-control split on index 3, and the masking of the side registers.

// File: rtl/ibr_pkg.sv
// Package: shared field positions and constants for the indirect register bridge.
// Assumes a 64-bit command word whose field positions are decoded by software.
package ibr_pkg;
    localparam int WORD_W      = 64;
    localparam int DATA_W      = 32;
    localparam int REG_W       = 8;
    localparam int IDX_W       = 3;
    localparam int OP_W        = 4;
    localparam int V_BIT       = 63;
    localparam int OP_LSB      = 57;
    localparam int R_BIT       = 56;
    localparam int IDX_LSB     = 32;
    localparam int NREG        = 1 << IDX_W;
    localparam logic [OP_W-1:0]  OP_INTERNAL = 4'd6;
    localparam logic [IDX_W-1:0] IDX_CLK     = 3'd3;
    localparam logic [IDX_W-1:0] IDX_RESET   = 3'd7;
    localparam logic [REG_W-1:0] STATUS_IDLE = 8'hF8;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [IDX_W-1:0]  idx;
        logic [REG_W-1:0]  wdata;
    } core_req_t;
endpackage

// File: rtl/ibr_host_decode.sv
// Module: host-side offset decode, side registers and read-back mux.
// Assumes host_wr is a one-cycle strobe; reads are combinational on host_addr.
module ibr_host_decode
    import ibr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFF_CMD   = 16'h1000,
    parameter int OFF_SW    = 16'h1008,
    parameter int OFF_INT   = 16'h1010,
    parameter int OFF_EXT   = 16'h1018,
    parameter int INT_BITS  = 12,
    parameter int EXT_BITS  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [REG_W-1:0]  status_val,
    input  logic [REG_W-1:0]  clkctl_val,
    output logic              wr_cmd,
    output logic [WORD_W-1:0] host_rdata
);
    logic sel_cmd, sel_sw, sel_int, sel_ext;
    logic [INT_BITS-1:0] int_q;
    logic [EXT_BITS-1:0] ext_q;

    // Offset compare for each host-visible word.
    always_comb begin
        sel_cmd = (host_addr == ADDR_W'(OFF_CMD));
        sel_sw  = (host_addr == ADDR_W'(OFF_SW));
        sel_int = (host_addr == ADDR_W'(OFF_INT));
        sel_ext = (host_addr == ADDR_W'(OFF_EXT));
        wr_cmd  = host_wr && sel_cmd;
    end

    // Storage for the interrupt/override and extended command words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= '0;
            ext_q <= '0;
        end else if (host_wr) begin
            if (sel_int) int_q <= host_wdata[INT_BITS-1:0];
            if (sel_ext) ext_q <= host_wdata[EXT_BITS-1:0];
        end
    end

    // Read-back mux; unmapped offsets return zero.
    always_comb begin
        host_rdata = '0;
        if (sel_cmd)      host_rdata = cmd_word;
        else if (sel_sw)  host_rdata = {{(WORD_W-2*REG_W){1'b0}}, clkctl_val, status_val};
        else if (sel_int) host_rdata = {{(WORD_W-INT_BITS){1'b0}}, int_q};
        else if (sel_ext) host_rdata = {{(WORD_W-EXT_BITS){1'b0}}, ext_q};
    end
endmodule

// File: rtl/ibr_cmd_engine.sv
// Module: command word register, valid-flag handshake and access sequencing.
// Assumes ACC_LAT >= 1; the internal access is issued on the last busy cycle.
module ibr_cmd_engine
    import ibr_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [WORD_W-1:0] wdata,
    input  logic [REG_W-1:0]  core_rdata,
    output core_req_t         core_req,
    output logic [WORD_W-1:0] cmd_word
);
    localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

    logic [WORD_W-1:0] cmd_q;
    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic              accept;
    logic              is_read;

    // Decode of the incoming word and of the final busy cycle.
    always_comb begin
        accept  = wdata[V_BIT] && (wdata[OP_LSB +: OP_W] == OP_INTERNAL);
        last    = busy && (cnt == '0);
        is_read = cmd_q[R_BIT];
    end

    // Command register, busy flag and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            busy  <= 1'b0;
            cnt   <= '0;
        end else if (busy) begin
            if (last) begin
                busy         <= 1'b0;
                cmd_q[V_BIT] <= 1'b0;
                if (is_read)
                    cmd_q[DATA_W-1:0] <= {{(DATA_W-REG_W){1'b0}}, core_rdata};
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (wr_cmd) begin
            if (accept) begin
                cmd_q <= wdata;
                busy  <= 1'b1;
                cnt   <= CNT_W'(ACC_LAT - 1);
            end else begin
                cmd_q <= {1'b0, wdata[WORD_W-2:0]};
            end
        end
    end

    // Internal register request, issued on the final busy cycle only.
    always_comb begin
        core_req.we    = last && !is_read;
        core_req.re    = last && is_read;
        core_req.idx   = cmd_q[IDX_LSB +: IDX_W];
        core_req.wdata = cmd_q[REG_W-1:0];
        cmd_word       = cmd_q;
    end

    // R3: v is held while the latency counter is still running.
    assert_v_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> cmd_q[V_BIT]);

    // R6: a host write during a non-final busy cycle leaves the word as it was.
    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0 && wr_cmd) |=> $stable(cmd_q));

    // R7: a word that is not an internal access is never left with v set.
    assert_nonaccess_clears_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_cmd && !accept) |=> !cmd_q[V_BIT]);
endmodule

// File: rtl/ibr_core_regs.sv
// Module: simple model of the bus controller's 8-bit internal register file.
// Assumes one request per cycle; index 3 write is clock control, read is status.
module ibr_core_regs
    import ibr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  core_req_t        req,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] status_val,
    output logic [REG_W-1:0] clkctl_val
);
    localparam logic [NREG-1:0] IMPL_MASK = 8'b0001_1111;

    logic [REG_W-1:0]      regs [NREG];
    logic [NREG*REG_W-1:0] snap;

    // One storage byte per implemented index; others stay zero.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (IMPL_MASK[g]) begin : g_impl
            // Byte register: cleared by reset or the soft-reset index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (req.we && req.idx == IDX_RESET)
                    regs[g] <= '0;
                else if (req.we && req.idx == IDX_W'(g))
                    regs[g] <= req.wdata;
            end
        end else begin : g_none
            assign regs[g] = '0;
        end
        assign snap[g*REG_W +: REG_W] = regs[g];
    end

    // Read select, with status substituted on the shared index.
    always_comb begin
        status_val = STATUS_IDLE;
        clkctl_val = regs[IDX_CLK];
        rdata      = (req.idx == IDX_CLK) ? STATUS_IDLE : regs[req.idx];
    end

    // R9: writes to unimplemented indexes change nothing.
    assert_unimpl_write_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req.we && (req.idx == 3'd5 || req.idx == 3'd6)) |=> $stable(snap));

    // R8: the soft-reset index clears the whole register file.
    assert_soft_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req.we && req.idx == IDX_RESET) |=> (snap == '0));
endmodule

// File: rtl/ibr_top.sv
// Module: top of the indirect register access bridge.
// Assumes a single host master; the core model stands in for the bus engine.
module ibr_top
    import ibr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata
);
    logic              wr_cmd;
    logic [WORD_W-1:0] cmd_word;
    core_req_t         core_req;
    logic [REG_W-1:0]  core_rdata, status_val, clkctl_val;

    ibr_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .cmd_word(cmd_word), .status_val(status_val),
        .clkctl_val(clkctl_val), .wr_cmd(wr_cmd), .host_rdata(host_rdata)
    );

    ibr_cmd_engine #(.ACC_LAT(ACC_LAT)) u_eng (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(host_wdata),
        .core_rdata(core_rdata), .core_req(core_req), .cmd_word(cmd_word)
    );

    ibr_core_regs u_core (
        .clk(clk), .rst_n(rst_n), .req(core_req), .rdata(core_rdata),
        .status_val(status_val), .clkctl_val(clkctl_val)
    );
endmodule

// File: tb/tb_ibr_top.sv
// Directed bench for the indirect register access bridge.
module tb_ibr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = 16'h0;
    logic [63:0] host_wdata = 64'h0;
    logic [63:0] host_rdata;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [15:0] A_CMD = 16'h1000, A_SW = 16'h1008,
                            A_INT = 16'h1010, A_EXT = 16'h1018;

    ibr_top dut (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
                 .host_wdata(host_wdata), .host_rdata(host_rdata));

    always #4 clk = ~clk;

    function automatic logic [63:0] mk(bit v, bit r, logic [3:0] op, logic [2:0] idx,
                                        logic [31:0] d);
        return (64'(v) << 63) | (64'(op) << 57) | (64'(r) << 56) | (64'(idx) << 32) | 64'(d);
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic hwrite(logic [15:0] a, logic [63:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [15:0] a, output logic [63:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic run_cmd(logic [63:0] w);
        hwrite(A_CMD, w);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        hread(A_CMD, d); check("R1 cmd", d, 64'h0);
        hread(A_SW, d);  check("R1 sw", d, 64'h00F8);
        hread(A_INT, d); check("R1 int", d, 64'h0);
        hread(A_EXT, d); check("R1 ext", d, 64'h0);
    endtask

    task automatic t_write_read;
        logic [63:0] d;
        logic [7:0] vals [4] = '{8'h5A, 8'hC3, 8'h44, 8'h91};
        logic [2:0] ids  [4] = '{3'd0, 3'd1, 3'd2, 3'd4};
        for (int i = 0; i < 4; i++) run_cmd(mk(1, 0, 4'd6, ids[i], {24'hABCDEF, vals[i]}));
        for (int i = 0; i < 4; i++) begin
            run_cmd(mk(1, 1, 4'd6, ids[i], 32'hFFFF_FFFF));
            hread(A_CMD, d);
            check("R2 R4 readback", d, mk(0, 1, 4'd6, ids[i], {24'h0, vals[i]}));
        end
    endtask

    task automatic t_timing;
        logic [63:0] d;
        hwrite(A_CMD, mk(1, 0, 4'd6, 3'd1, 32'h77));
        hread(A_CMD, d); check("R3 v cycle1", 64'(d[63]), 64'd1);
        @(negedge clk);
        hread(A_CMD, d); check("R3 v cycle2", 64'(d[63]), 64'd1);
        @(negedge clk);
        hread(A_CMD, d); check("R3 v cleared", 64'(d[63]), 64'd0);
    endtask

    task automatic t_shared_index;
        logic [63:0] d;
        run_cmd(mk(1, 0, 4'd6, 3'd3, 32'h3B));
        hread(A_SW, d); check("R5 clkctl", d, 64'h3BF8);
        run_cmd(mk(1, 1, 4'd6, 3'd3, 32'h0));
        hread(A_CMD, d); check("R5 status", d, mk(0, 1, 4'd6, 3'd3, 32'hF8));
    endtask

    task automatic t_busy_ignore;
        logic [63:0] d;
        hwrite(A_CMD, mk(1, 0, 4'd6, 3'd2, 32'h12));
        hwrite(A_CMD, mk(1, 0, 4'd6, 3'd2, 32'hEE));
        repeat (2) @(negedge clk);
        hread(A_CMD, d); check("R6 word kept", d, mk(0, 0, 4'd6, 3'd2, 32'h12));
        run_cmd(mk(1, 1, 4'd6, 3'd2, 32'h0));
        hread(A_CMD, d); check("R6 reg kept", d, mk(0, 1, 4'd6, 3'd2, 32'h12));
    endtask

    task automatic t_other_op;
        logic [63:0] d;
        hwrite(A_CMD, mk(1, 0, 4'd5, 3'd2, 32'h99));
        hread(A_CMD, d); check("R7 immediate", d, mk(0, 0, 4'd5, 3'd2, 32'h99));
        hwrite(A_CMD, mk(0, 0, 4'd6, 3'd2, 32'h98));
        hread(A_CMD, d); check("R7 v0 stored", d, mk(0, 0, 4'd6, 3'd2, 32'h98));
        run_cmd(mk(1, 1, 4'd6, 3'd2, 32'h0));
        hread(A_CMD, d); check("R7 reg kept", d, mk(0, 1, 4'd6, 3'd2, 32'h12));
    endtask

    task automatic t_unimpl;
        logic [63:0] d;
        run_cmd(mk(1, 0, 4'd6, 3'd5, 32'hAA));
        run_cmd(mk(1, 0, 4'd6, 3'd6, 32'hBB));
        run_cmd(mk(1, 1, 4'd6, 3'd5, 32'h0));
        hread(A_CMD, d); check("R9 idx5", d, mk(0, 1, 4'd6, 3'd5, 32'h0));
        run_cmd(mk(1, 1, 4'd6, 3'd1, 32'h0));
        hread(A_CMD, d); check("R9 idx1 kept", d, mk(0, 1, 4'd6, 3'd1, 32'h77));
    endtask

    task automatic t_soft_reset;
        logic [63:0] d;
        run_cmd(mk(1, 0, 4'd6, 3'd7, 32'h1));
        hread(A_SW, d); check("R8 clkctl cleared", d, 64'h00F8);
        run_cmd(mk(1, 1, 4'd6, 3'd0, 32'h0));
        hread(A_CMD, d); check("R8 slave cleared", d, mk(0, 1, 4'd6, 3'd0, 32'h0));
    endtask

    task automatic t_side_regs;
        logic [63:0] d;
        hwrite(A_INT, 64'hFFFF_FFFF_FFFF_FFFF);
        hread(A_INT, d); check("R10 int mask", d, 64'hFFF);
        hwrite(A_EXT, 64'hFFFF_FFFF_FFFF_FFFF);
        hread(A_EXT, d); check("R10 ext mask", d, 64'hFF_FFFF_FFFF);
        hwrite(16'h1020, 64'h1234);
        hread(16'h1020, d); check("R10 unmapped", d, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_timing();
        t_shared_index();
        t_busy_ignore();
        t_other_op();
        t_unimpl();
        t_soft_reset();
        t_side_regs();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule